// File: doc/BRIEF.md
# Scoreboard Hazard Controller for Floating-Point Units

This block is the central hazard controller for a group of floating-point functional units. It takes one decoded instruction per cycle through a valid/ready handshake. The instruction carries an operation code, a destination register, two source registers and the index of the unit that will run it. Instructions leave a single-entry holding stage strictly in program order. Once a unit has received its instruction, that unit is told separately when to read its operands, when to start executing and when to write its result. Operand reads, execution and result writes can therefore happen out of program order.

The controller keeps one status record per unit. The record holds the unit state, the operation, the destination and source registers, the tags of the units that produce the sources, and one ready flag per source. The controller also keeps a result table that maps each register to the unit that will write it. Read-after-write hazards are resolved by holding the operand read until both sources are ready. Write-after-write hazards and busy units are handled by refusing to issue. Write-after-read hazards are handled by holding back a finished unit's result while an earlier instruction still needs the old register value. The datapath, the register contents and the operand forwarding are outside this block.

Top module: `fu_scoreboard`

## Requirements
- R1: An instruction is issued only when its unit is idle and no issued instruction still targets its destination register. A held instruction stays in the holding stage, and `in_ready` stays low while it waits.
- R2: Issue is in program order. `in_ready` is high when the holding stage is empty or when its instruction issues in that cycle. A later instruction never reaches a unit before an earlier blocked one.
- R3: When neither source is pending, the unit's `rd_grant` rises two cycles after the cycle in which the instruction was accepted.
- R4: When a source is pending, `rd_grant` is withheld until the producing unit's `wb_grant`. It is asserted in the cycle after that grant if the other source is ready.
- R5: `rd_grant` is a one-cycle pulse for each instruction. After the read, that unit no longer holds back writes to its source registers.
- R6: `ex_start[u]` pulses one cycle after `rd_grant[u]`. In that cycle the slot `ex_op[4u+3:4u]` holds the instruction's operation code.
- R7: A `done[u]` pulse during execution makes unit u eligible for `wb_grant` in the next cycle. Outside execution, `done[u]` is ignored.
- R8: A finished unit's `wb_grant` is withheld while another unit is waiting to read an operand whose source register equals the finished unit's destination and whose ready flag is set.
- R9: At most one `wb_grant` bit is high per cycle. When several units are eligible, the lowest index wins.
- R10: After `wb_grant`, the unit and its destination register are free in the next cycle. An instruction held for either reaches `rd_grant` two cycles after the grant.
- R11: After reset, `in_ready` is high and `rd_grant`, `ex_start` and `wb_grant` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Decoded instruction present |
| in_ready | output | 1 | Holding stage can take an instruction |
| in_op | input | 4 | Operation code |
| in_dst | input | 5 | Destination register |
| in_src1 | input | 5 | First source register |
| in_src2 | input | 5 | Second source register |
| in_fu | input | 2 | Target functional unit index |
| done | input | 4 | Per-unit execution finished pulse |
| rd_grant | output | 4 | Per-unit read-operands permission |
| ex_start | output | 4 | Per-unit execute start pulse |
| ex_op | output | 16 | Operation code of each unit, 4 bits per unit |
| wb_grant | output | 4 | Per-unit write-result permission |

## Verification
An instruction accepted in cycle a reaches `rd_grant` at a+2 and `ex_start` at a+3 when its sources are free. A read that waits on a producer follows that producer's write grant by one cycle. An instruction held for a busy unit or a pending destination reaches its read grant two cycles after the write grant that frees it. A `done` pulse seen in cycle c gives a write grant at c+1, and later only if arbitration or a write-after-read hold delays it. The bench drives inputs and samples outputs on falling edges. A monitor logs the cycle of every grant and pulse, and each check compares those cycle numbers with values derived from these delays, together with the cycle numbers of the grants the check depends on.

// File: rtl/sb_pkg.sv
package sb_pkg;
    localparam int NUM_REGS = 32;
    localparam int NUM_FUS  = 4;
    localparam int OP_W     = 4;
    localparam int REG_W    = $clog2(NUM_REGS);
    localparam int FU_W     = $clog2(NUM_FUS);
    localparam int TAG_W    = $clog2(NUM_FUS + 1);

    typedef logic [OP_W-1:0]  op_t;
    typedef logic [REG_W-1:0] reg_id_t;
    typedef logic [FU_W-1:0]  fu_id_t;
    typedef logic [TAG_W-1:0] tag_t;

    localparam tag_t TAG_NONE = '0;

    typedef struct packed {
        op_t     op;
        reg_id_t dst;
        reg_id_t src1;
        reg_id_t src2;
        fu_id_t  fu;
    } instr_t;

    typedef enum logic [1:0] {
        FU_IDLE    = 2'd0,
        FU_WAIT_RD = 2'd1,
        FU_EXEC    = 2'd2,
        FU_WAIT_WB = 2'd3
    } fu_state_e;

    typedef struct packed {
        fu_state_e st;
        op_t       op;
        reg_id_t   fi;
        reg_id_t   fj;
        reg_id_t   fk;
        tag_t      qj;
        tag_t      qk;
        logic      rj;
        logic      rk;
    } fu_entry_t;

    function automatic tag_t tag_of(fu_id_t idx);
        return tag_t'(idx) + tag_t'(1);
    endfunction
endpackage

// File: rtl/sb_hold_buf.sv
module sb_hold_buf
    import sb_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   in_valid,
    input  instr_t in_instr,
    output logic   in_ready,
    output logic   out_valid,
    output instr_t out_instr,
    input  logic   out_take
);
    logic   full_q;
    instr_t data_q;

    assign in_ready  = !full_q || out_take;
    assign out_valid = full_q;
    assign out_instr = data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= 1'b0;
        end else if (in_valid && in_ready) begin
            full_q <= 1'b1;
            data_q <= in_instr;
        end else if (out_take) begin
            full_q <= 1'b0;
        end
    end
endmodule

// File: rtl/sb_regstat.sv
module sb_regstat
    import sb_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    set_en,
    input  reg_id_t set_reg,
    input  tag_t    set_tag,
    input  logic    clr_en,
    input  reg_id_t clr_reg,
    input  reg_id_t rd_a,
    input  reg_id_t rd_b,
    input  reg_id_t rd_c,
    output tag_t    tag_a,
    output tag_t    tag_b,
    output tag_t    tag_c
);
    tag_t owner_q [NUM_REGS];

    assign tag_a = owner_q[rd_a];
    assign tag_b = owner_q[rd_b];
    assign tag_c = owner_q[rd_c];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < NUM_REGS; r++) owner_q[r] <= TAG_NONE;
        end else begin
            if (clr_en) owner_q[clr_reg] <= TAG_NONE;
            if (set_en) owner_q[set_reg] <= set_tag;
        end
    end
endmodule

// File: rtl/sb_wb_arb.sv
module sb_wb_arb
    import sb_pkg::*;
(
    input  fu_entry_t          ent [NUM_FUS],
    output logic [NUM_FUS-1:0] wb_grant,
    output logic               wb_any,
    output fu_id_t             wb_idx
);
    logic [NUM_FUS-1:0] war_hold;
    logic [NUM_FUS-1:0] eligible;

    // A waiting reader that still wants the old value of our destination blocks us.
    always_comb begin
        war_hold = '0;
        for (int u = 0; u < NUM_FUS; u++) begin
            for (int v = 0; v < NUM_FUS; v++) begin
                if (v != u && ent[v].st == FU_WAIT_RD &&
                    ((ent[v].fj == ent[u].fi && ent[v].rj) ||
                     (ent[v].fk == ent[u].fi && ent[v].rk)))
                    war_hold[u] = 1'b1;
            end
            eligible[u] = (ent[u].st == FU_WAIT_WB) && !war_hold[u];
        end
    end

    always_comb begin
        wb_grant = '0;
        wb_any   = 1'b0;
        wb_idx   = '0;
        for (int u = 0; u < NUM_FUS; u++) begin
            if (eligible[u] && !wb_any) begin
                wb_grant[u] = 1'b1;
                wb_any      = 1'b1;
                wb_idx      = fu_id_t'(u);
            end
        end
    end
endmodule

// File: rtl/fu_scoreboard.sv
module fu_scoreboard
    import sb_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [OP_W-1:0]         in_op,
    input  logic [REG_W-1:0]        in_dst,
    input  logic [REG_W-1:0]        in_src1,
    input  logic [REG_W-1:0]        in_src2,
    input  logic [FU_W-1:0]         in_fu,
    input  logic [NUM_FUS-1:0]      done,
    output logic [NUM_FUS-1:0]      rd_grant,
    output logic [NUM_FUS-1:0]      ex_start,
    output logic [NUM_FUS*OP_W-1:0] ex_op,
    output logic [NUM_FUS-1:0]      wb_grant
);
    instr_t             in_instr;
    instr_t             hb_instr;
    logic               hb_valid;
    logic               issue_fire;
    tag_t               tag_dst, tag_s1, tag_s2;
    logic               wb_any;
    fu_id_t             wb_idx;
    tag_t               wb_tag;
    logic               s1_pend, s2_pend;
    logic [NUM_FUS-1:0] busy_v;
    logic [NUM_FUS-1:0] ex_start_q;
    fu_entry_t          ent [NUM_FUS];

    assign in_instr = '{op: in_op, dst: in_dst, src1: in_src1, src2: in_src2, fu: in_fu};

    sb_hold_buf u_hold (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_instr  (in_instr),
        .in_ready  (in_ready),
        .out_valid (hb_valid),
        .out_instr (hb_instr),
        .out_take  (issue_fire)
    );

    sb_wb_arb u_arb (
        .ent      (ent),
        .wb_grant (wb_grant),
        .wb_any   (wb_any),
        .wb_idx   (wb_idx)
    );

    sb_regstat u_rstat (
        .clk     (clk),
        .rst     (rst),
        .set_en  (issue_fire),
        .set_reg (hb_instr.dst),
        .set_tag (tag_of(hb_instr.fu)),
        .clr_en  (wb_any),
        .clr_reg (ent[wb_idx].fi),
        .rd_a    (hb_instr.dst),
        .rd_b    (hb_instr.src1),
        .rd_c    (hb_instr.src2),
        .tag_a   (tag_dst),
        .tag_b   (tag_s1),
        .tag_c   (tag_s2)
    );

    assign wb_tag     = tag_of(wb_idx);
    assign issue_fire = hb_valid && !busy_v[hb_instr.fu] && (tag_dst == TAG_NONE);
    // A producer that writes back in the issue cycle counts as already done.
    assign s1_pend = (tag_s1 != TAG_NONE) && !(wb_any && tag_s1 == wb_tag);
    assign s2_pend = (tag_s2 != TAG_NONE) && !(wb_any && tag_s2 == wb_tag);
    assign ex_start = ex_start_q;

    genvar g;
    generate
        for (g = 0; g < NUM_FUS; g++) begin : g_unit
            assign busy_v[g]  = ent[g].st != FU_IDLE;
            assign rd_grant[g] = (ent[g].st == FU_WAIT_RD) && ent[g].rj && ent[g].rk;
            assign ex_op[g*OP_W +: OP_W] = ent[g].op;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            ex_start_q <= '0;
            for (int u = 0; u < NUM_FUS; u++) ent[u] <= '0;
        end else begin
            ex_start_q <= rd_grant;
            for (int u = 0; u < NUM_FUS; u++) begin
                unique case (ent[u].st)
                    FU_IDLE: begin
                        if (issue_fire && hb_instr.fu == fu_id_t'(u)) begin
                            ent[u].st <= FU_WAIT_RD;
                            ent[u].op <= hb_instr.op;
                            ent[u].fi <= hb_instr.dst;
                            ent[u].fj <= hb_instr.src1;
                            ent[u].fk <= hb_instr.src2;
                            ent[u].qj <= s1_pend ? tag_s1 : TAG_NONE;
                            ent[u].qk <= s2_pend ? tag_s2 : TAG_NONE;
                            ent[u].rj <= !s1_pend;
                            ent[u].rk <= !s2_pend;
                        end
                    end
                    FU_WAIT_RD: begin
                        if (rd_grant[u]) begin
                            ent[u].st <= FU_EXEC;
                            ent[u].rj <= 1'b0;
                            ent[u].rk <= 1'b0;
                        end else begin
                            if (wb_any && ent[u].qj == wb_tag) begin
                                ent[u].rj <= 1'b1;
                                ent[u].qj <= TAG_NONE;
                            end
                            if (wb_any && ent[u].qk == wb_tag) begin
                                ent[u].rk <= 1'b1;
                                ent[u].qk <= TAG_NONE;
                            end
                        end
                    end
                    FU_EXEC: begin
                        if (done[u]) ent[u].st <= FU_WAIT_WB;
                    end
                    FU_WAIT_WB: begin
                        if (wb_grant[u]) ent[u].st <= FU_IDLE;
                    end
                    default: ent[u].st <= FU_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/sb_checker.sv
module sb_checker
    import sb_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [NUM_FUS-1:0] rd_grant,
    input logic [NUM_FUS-1:0] ex_start,
    input logic [NUM_FUS-1:0] wb_grant,
    input logic [NUM_FUS-1:0] busy_v,
    input logic               issue_fire,
    input fu_id_t             issue_fu
);
    logic [NUM_FUS-1:0] fu_oh;
    assign fu_oh = {{(NUM_FUS-1){1'b0}}, 1'b1} << issue_fu;

    assert_one_wb_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wb_grant));

    assert_issue_claim_R1: assert property (@(posedge clk) disable iff (rst)
        issue_fire |=> ((busy_v & $past(fu_oh)) != '0));

    genvar g;
    generate
        for (g = 0; g < NUM_FUS; g++) begin : g_chk
            assert_rd_pulse_R5: assert property (@(posedge clk) disable iff (rst)
                rd_grant[g] |=> !rd_grant[g]);
            assert_ex_follow_R6: assert property (@(posedge clk) disable iff (rst)
                ex_start[g] == $past(rd_grant[g]));
            assert_wb_free_R10: assert property (@(posedge clk) disable iff (rst)
                wb_grant[g] |=> !busy_v[g]);
        end
    endgenerate
endmodule

bind fu_scoreboard sb_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .rd_grant   (rd_grant),
    .ex_start   (ex_start),
    .wb_grant   (wb_grant),
    .busy_v     (busy_v),
    .issue_fire (issue_fire),
    .issue_fu   (hb_instr.fu)
);

// File: tb/fu_scoreboard_bench.sv
`timescale 1ns/1ps
module fu_scoreboard_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [3:0]  in_op = '0;
    logic [4:0]  in_dst = '0, in_src1 = '0, in_src2 = '0;
    logic [1:0]  in_fu = '0;
    logic [3:0]  done = '0;
    logic [3:0]  rd_grant, ex_start, wb_grant;
    logic [15:0] ex_op;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int rd_cyc [4];
    int ex_cyc [4];
    int ex_opv [4];
    int wb_cyc [4];
    int rd_cnt [4];
    int multi_wb = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    fu_scoreboard u_fu_scoreboard (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
        .in_fu(in_fu), .done(done), .rd_grant(rd_grant), .ex_start(ex_start),
        .ex_op(ex_op), .wb_grant(wb_grant)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst) begin
            for (int u = 0; u < 4; u++) begin
                if (rd_grant[u]) begin rd_cyc[u] = cyc; rd_cnt[u]++; end
                if (ex_start[u]) begin ex_cyc[u] = cyc; ex_opv[u] = int'(ex_op[u*4 +: 4]); end
                if (wb_grant[u]) wb_cyc[u] = cyc;
            end
            if ($countones(wb_grant) > 1) multi_wb++;
        end
    end

    typedef struct packed {
        logic [3:0] op;
        logic [4:0] dst;
        logic [4:0] s1;
        logic [4:0] s2;
        logic [1:0] fu;
    } vec_t;

    localparam vec_t VEC [4] = '{
        '{op: 4'd3,  dst: 5'd10, s1: 5'd1, s2: 5'd2, fu: 2'd0},
        '{op: 4'd5,  dst: 5'd11, s1: 5'd3, s2: 5'd4, fu: 2'd1},
        '{op: 4'd9,  dst: 5'd12, s1: 5'd1, s2: 5'd3, fu: 2'd2},
        '{op: 4'd12, dst: 5'd13, s1: 5'd2, s2: 5'd4, fu: 2'd3}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_log();
        for (int u = 0; u < 4; u++) begin
            rd_cyc[u] = -1; ex_cyc[u] = -1; ex_opv[u] = -1; wb_cyc[u] = -1; rd_cnt[u] = 0;
        end
    endtask

    task automatic send(input int op, input int dst, input int s1, input int s2,
                        input int fu, output int acc);
        @(negedge clk);
        in_valid = 1'b1;
        in_op = 4'(op); in_dst = 5'(dst); in_src1 = 5'(s1); in_src2 = 5'(s2); in_fu = 2'(fu);
        while (!in_ready) @(negedge clk);
        acc = cyc;
        @(posedge clk);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic pulse(input logic [3:0] mask, output int c);
        @(negedge clk);
        done = mask;
        c = cyc;
        @(negedge clk);
        done = '0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #3000000;
        if (!finished) begin
            failures++;
            $display("FAIL R11 watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int acc [4];
        int a0, a1, a2, c, c2;
        clear_log();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 reset state
        check(in_ready == 1'b1, "R11 in_ready", int'(in_ready), 1);
        check(rd_grant == 0 && ex_start == 0 && wb_grant == 0, "R11 grants",
              int'({rd_grant, ex_start, wb_grant}), 0);

        // Vector table: independent instructions, back to back
        clear_log();
        for (int i = 0; i < 4; i++)
            send(int'(VEC[i].op), int'(VEC[i].dst), int'(VEC[i].s1), int'(VEC[i].s2),
                 int'(VEC[i].fu), acc[i]);
        idle();
        wait_cyc(5);
        for (int i = 0; i < 4; i++) begin
            check(rd_cyc[i] == acc[i] + 2, "R3 read grant timing", rd_cyc[i], acc[i] + 2);
            check(ex_cyc[i] == acc[i] + 3, "R6 execute start timing", ex_cyc[i], acc[i] + 3);
            check(ex_opv[i] == int'(VEC[i].op), "R6 execute op", ex_opv[i], int'(VEC[i].op));
            check(rd_cnt[i] == 1, "R5 single read pulse", rd_cnt[i], 1);
        end
        pulse(4'hF, c);
        wait_cyc(6);
        for (int u = 0; u < 4; u++)
            check(wb_cyc[u] == c + 1 + u, "R9 lowest index first / R7", wb_cyc[u], c + 1 + u);
        check(multi_wb == 0, "R9 one grant per cycle", multi_wb, 0);

        // R7: done outside execution is ignored
        clear_log();
        pulse(4'h2, c);
        wait_cyc(3);
        check(wb_cyc[1] == -1, "R7 stray done ignored", wb_cyc[1], -1);

        // R1: destination pending blocks issue
        clear_log();
        send(1, 5, 1, 2, 0, a0);
        send(2, 5, 3, 4, 1, a1);
        idle();
        check(in_ready == 1'b0, "R1 stall holds in_ready low", int'(in_ready), 0);
        wait_cyc(4);
        check(rd_cyc[1] == -1, "R1 no issue while dst pending", rd_cyc[1], -1);
        pulse(4'h1, c);
        wait_cyc(4);
        check(wb_cyc[0] == c + 1, "R7 writeback after done", wb_cyc[0], c + 1);
        check(rd_cyc[1] == wb_cyc[0] + 2, "R1 issue after dst freed", rd_cyc[1], wb_cyc[0] + 2);
        wait_cyc(2);
        pulse(4'h2, c);
        wait_cyc(3);

        // R10 busy unit and R2 ordering behind a blocked instruction
        clear_log();
        send(4, 7, 1, 2, 0, a0);
        send(6, 8, 3, 4, 0, a1);
        fork
            send(7, 20, 1, 1, 3, a2);
            begin
                wait_cyc(5);
                pulse(4'h1, c);
            end
        join
        idle();
        wait_cyc(5);
        check(rd_cyc[0] == wb_cyc[0] + 2, "R10 freed unit reissues", rd_cyc[0], wb_cyc[0] + 2);
        check(rd_cyc[3] == wb_cyc[0] + 3, "R2 later instr waits in order", rd_cyc[3], wb_cyc[0] + 3);
        pulse(4'h9, c);
        wait_cyc(4);

        // R4 read-after-write
        clear_log();
        send(1, 2, 1, 1, 0, a0);
        send(2, 9, 2, 3, 1, a1);
        idle();
        wait_cyc(5);
        check(rd_cyc[1] == -1, "R4 read held for producer", rd_cyc[1], -1);
        pulse(4'h1, c);
        wait_cyc(4);
        check(rd_cyc[1] == wb_cyc[0] + 1, "R4 read after producer write", rd_cyc[1], wb_cyc[0] + 1);
        pulse(4'h2, c);
        wait_cyc(3);

        // R8 write-after-read
        clear_log();
        send(3, 6, 1, 1, 2, a0);
        send(4, 8, 4, 6, 0, a1);
        send(5, 4, 1, 2, 1, a2);
        idle();
        wait_cyc(5);
        pulse(4'h2, c);
        wait_cyc(6);
        check(wb_cyc[1] == -1, "R8 write held for earlier reader", wb_cyc[1], -1);
        pulse(4'h4, c2);
        wait_cyc(6);
        check(wb_cyc[2] == c2 + 1, "R7 producer writes back", wb_cyc[2], c2 + 1);
        check(rd_cyc[0] == wb_cyc[2] + 1, "R4 reader wakes", rd_cyc[0], wb_cyc[2] + 1);
        check(wb_cyc[1] == rd_cyc[0] + 1, "R8 write released after read / R5", wb_cyc[1], rd_cyc[0] + 1);
        pulse(4'h1, c);
        wait_cyc(3);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule